// File: doc/BRIEF.md
# Pipelined Four-Mode Barrel Shifter

This block shifts an 8-bit word by 0 to 7 places in one of four modes: rotate right, logical left, logical right and arithmetic right. The work is split into five registered stages. The first stage reverses the bit order if the operation is a left shift. The next three stages each move the word right by 1, 2 or 4 places when their bit of the shift amount is set. The last stage undoes the reversal for left shifts. Because left shifts are done this way, each stage only needs a right-shift path.

The shift amount, the mode and a valid flag are registered together with the data at every stage boundary. Each stage therefore works with the controls of the operation it currently holds. A new operation may enter on every clock cycle. Its result leaves exactly five cycles later, so up to five operations can be in the pipeline at once. There is no stall path.

Top module: `pipe_barrel_shifter`

## Requirements
- R1: With mode code 00 (rotate right), the result is the input rotated right by `in_amt` places: the bits shifted out at the low end come back in at the high end.
- R2: With mode code 01 (logical left), the result is the input shifted left by `in_amt` places, with zeros filling the low bits.
- R3: With mode code 10 (logical right), the result is the input shifted right by `in_amt` places, with zeros filling the high bits.
- R4: With mode code 11 (arithmetic right), the result is the input shifted right by `in_amt` places, with copies of input bit 7 filling the high bits.
- R5: A shift amount of 0 returns the input unchanged in every mode.
- R6: `out_valid` rises exactly five clock cycles after the cycle in which `in_valid` was sampled high, and `out_data` then holds that operation's result.
- R7: Operations presented on consecutive cycles, each with a different mode and amount, each produce their own correct result on consecutive output cycles.
- R8: While the synchronous active-high `rst` is sampled high, every valid flag in the pipeline is cleared, so `out_valid` is low after that edge and stays low until a new valid input has travelled through.
- R9: A cycle in which `in_valid` is low becomes a bubble: `out_valid` is low five cycles later.
- R10: The mode and amount held by each stage are exactly those that entered the previous stage together with the same data one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages update on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the valid flags |
| in_valid | input | 1 | The operation on the inputs this cycle is real |
| in_data | input | 8 | Word to shift |
| in_amt | input | 3 | Shift distance, 0 to 7 |
| in_mode | input | 2 | Mode code: 00 rotate right, 01 logical left, 10 logical right, 11 arithmetic right |
| out_valid | output | 1 | `out_data` holds a completed result |
| out_data | output | 8 | Shifted word |

## Verification
The hardest case to reach is when every stage holds a different operation and each stage must apply only its own controls. An error there appears only if neighbouring operations differ in mode and amount. The stimulus therefore streams every combination of data, amount and mode with no gaps, and the mode changes on every cycle while the amount and data change underneath it. It also resets the pipeline while it is full, and mixes bubbles with valid cycles, to test that the valid flags stay aligned with the data.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [1:0] {
        MODE_ROTR = 2'b00,
        MODE_SHL  = 2'b01,
        MODE_SHR  = 2'b10,
        MODE_ASR  = 2'b11
    } shift_mode_e;

endpackage

// File: rtl/pbs_reverse_stage.sv
module pbs_reverse_stage
    import pbs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AMT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  shift_mode_e       in_mode,
    input  logic [AMT_W-1:0]  in_amt,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output shift_mode_e       out_mode,
    output logic [AMT_W-1:0]  out_amt,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] flipped;
    logic [DATA_W-1:0] next_data;

    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        assign flipped[i] = in_data[DATA_W-1-i];
    end

    always_comb begin
        next_data = (in_mode == MODE_SHL) ? flipped : in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        out_mode <= in_mode;
        out_amt  <= in_amt;
        out_data <= next_data;
    end

    // Controls travel with the data (R10)
    assert_ctrl_follow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_mode == $past(in_mode)) && (out_amt == $past(in_amt)));

    // A stage that does not reverse keeps the word as it is (R5)
    assert_no_flip_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode != MODE_SHL) |=> out_data == $past(in_data));

endmodule

// File: rtl/pbs_shift_stage.sv
module pbs_shift_stage
    import pbs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AMT_W  = 3,
    parameter int LEVEL  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  shift_mode_e       in_mode,
    input  logic [AMT_W-1:0]  in_amt,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output shift_mode_e       out_mode,
    output logic [AMT_W-1:0]  out_amt,
    output logic [DATA_W-1:0] out_data
);

    localparam int SHIFT = 1 << LEVEL;

    logic [SHIFT-1:0]  fill;
    logic [DATA_W-1:0] moved;
    logic [DATA_W-1:0] next_data;

    always_comb begin
        unique case (in_mode)
            MODE_ROTR: fill = in_data[SHIFT-1:0];
            MODE_ASR:  fill = {SHIFT{in_data[DATA_W-1]}};
            default:   fill = '0;
        endcase
        moved     = {fill, in_data[DATA_W-1:SHIFT]};
        next_data = in_amt[LEVEL] ? moved : in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        out_mode <= in_mode;
        out_amt  <= in_amt;
        out_data <= next_data;
    end

    // Controls travel with the data (R10)
    assert_ctrl_follow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_mode == $past(in_mode)) && (out_amt == $past(in_amt)));

    // Amount bit clear: the stage passes its word untouched (R5)
    assert_bit_clear_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_amt[LEVEL]) |=> out_data == $past(in_data));

    // Arithmetic shift keeps the sign bit (R4)
    assert_sign_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == MODE_ASR) |=> out_data[DATA_W-1] == $past(in_data[DATA_W-1]));

endmodule

// File: rtl/pipe_barrel_shifter.sv
module pipe_barrel_shifter
    import pbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic [2:0]        in_amt,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [7:0]        out_data
);

    localparam int AMT_W   = $clog2(DATA_W);
    localparam int LAST    = AMT_W + 2;
    localparam int LATENCY = LAST;

    logic              vld_s  [0:LAST];
    shift_mode_e       mode_s [0:LAST];
    logic [AMT_W-1:0]  amt_s  [0:LAST];
    logic [DATA_W-1:0] data_s [0:LAST];

    assign vld_s[0]  = in_valid;
    assign mode_s[0] = shift_mode_e'(in_mode);
    assign amt_s[0]  = in_amt;
    assign data_s[0] = in_data;

    pbs_reverse_stage #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rev_in (
        .clk(clk), .rst(rst),
        .in_valid(vld_s[0]), .in_mode(mode_s[0]), .in_amt(amt_s[0]), .in_data(data_s[0]),
        .out_valid(vld_s[1]), .out_mode(mode_s[1]), .out_amt(amt_s[1]), .out_data(data_s[1])
    );

    for (genvar lv = 0; lv < AMT_W; lv++) begin : g_lvl
        pbs_shift_stage #(.DATA_W(DATA_W), .AMT_W(AMT_W), .LEVEL(lv)) u_shift (
            .clk(clk), .rst(rst),
            .in_valid(vld_s[lv+1]), .in_mode(mode_s[lv+1]),
            .in_amt(amt_s[lv+1]), .in_data(data_s[lv+1]),
            .out_valid(vld_s[lv+2]), .out_mode(mode_s[lv+2]),
            .out_amt(amt_s[lv+2]), .out_data(data_s[lv+2])
        );
    end

    pbs_reverse_stage #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rev_out (
        .clk(clk), .rst(rst),
        .in_valid(vld_s[LAST-1]), .in_mode(mode_s[LAST-1]),
        .in_amt(amt_s[LAST-1]), .in_data(data_s[LAST-1]),
        .out_valid(vld_s[LAST]), .out_mode(mode_s[LAST]),
        .out_amt(amt_s[LAST]), .out_data(data_s[LAST])
    );

    assign out_valid = vld_s[LAST];
    assign out_data  = data_s[LAST];

    // Cycles since reset, saturating, so latency checks never look before reset
    logic [3:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 4'(LATENCY)) begin
            age_q <= age_q + 4'd1;
        end
    end

    assert_fixed_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (age_q == 4'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY)));

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_shl_zero_lsb_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_s[LAST] == MODE_SHL && amt_s[LAST] != '0) |-> !out_data[0]);

    assert_shr_zero_msb_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_s[LAST] == MODE_SHR && amt_s[LAST] != '0) |-> !out_data[DATA_W-1]);

endmodule

// File: tb/pipe_barrel_shifter_tb_top.sv
module pipe_barrel_shifter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [2:0] in_amt = '0;
    logic [1:0] in_mode = '0;
    logic       out_valid;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;

    logic       hv [0:4];
    logic [7:0] hd [0:4];
    logic [2:0] ha [0:4];
    logic [1:0] hm [0:4];
    string      zero_tag = "R9";

    always #5 clk = ~clk;

    pipe_barrel_shifter dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_amt(in_amt), .in_mode(in_mode), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [7:0] model(input logic [7:0] d, input logic [2:0] a,
                                         input logic [1:0] m);
        logic [15:0] twice;
        twice = {d, d} >> a;
        case (m)
            2'b00:   return twice[7:0];
            2'b01:   return d << a;
            2'b10:   return d >> a;
            default: return 8'($signed(d) >>> a);
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a, input logic [1:0] m);
        if (a == 3'd0) return "R5";
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_byte(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s out_data actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < 5; i++) begin
            hv[i] = 1'b0; hd[i] = '0; ha[i] = '0; hm[i] = '0;
        end
    endtask

    // Sample outputs at the falling edge, then push the new operation.
    // An entry pushed here reaches hist[4] five falling edges later,
    // which is when its result shows up (R6).
    task automatic apply(input logic v, input logic [7:0] d, input logic [2:0] a,
                         input logic [1:0] m);
        @(negedge clk);
        check_bit(hv[4] ? "R6" : zero_tag, out_valid, hv[4]);
        if (hv[4]) check_byte(tag_of(ha[4], hm[4]), out_data, model(hd[4], ha[4], hm[4]));
        for (int i = 4; i > 0; i--) begin
            hv[i] = hv[i-1]; hd[i] = hd[i-1]; ha[i] = ha[i-1]; hm[i] = hm[i-1];
        end
        hv[0] = v; hd[0] = d; ha[0] = a; hm[0] = m;
        in_valid = v; in_data = d; in_amt = a; in_mode = m;
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) apply(1'b0, 8'h00, 3'd0, 2'b00);
    endtask

    task automatic test_reset_state();
        clear_hist();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_bit("R8", out_valid, 1'b0);
        rst = 1'b0;
    endtask

    task automatic test_one_mode(input logic [1:0] m);
        for (int a = 0; a < 8; a++) begin
            apply(1'b1, 8'hB5, 3'(a), m);
            apply(1'b1, 8'h4C, 3'(a), m);
        end
        drain();
    endtask

    // R7: mode changes every cycle, amount and data change beneath it
    task automatic test_mixed_stream();
        for (int d = 0; d < 256; d++)
            for (int a = 0; a < 8; a++)
                for (int m = 0; m < 4; m++)
                    apply(1'b1, 8'(d), 3'(a), 2'(m));
        drain();
    endtask

    // R9: bubbles interleaved with valid operations
    task automatic test_bubbles();
        for (int i = 0; i < 24; i++)
            apply(i % 3 != 0, 8'(i * 37 + 11), 3'(i), 2'(i >> 1));
        drain();
    endtask

    // R8: reset while the pipeline is full
    task automatic test_midstream_reset();
        for (int i = 0; i < 5; i++) apply(1'b1, 8'(8'h91 + i), 3'(i + 1), 2'(i));
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        clear_hist();
        @(negedge clk);
        check_bit("R8", out_valid, 1'b0);
        rst = 1'b0; in_valid = 1'b0;
        zero_tag = "R8";
        for (int i = 0; i < 6; i++) apply(1'b0, 8'hFF, 3'd7, 2'b11);
        zero_tag = "R9";
        apply(1'b1, 8'h80, 3'd3, 2'b11);
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        test_reset_state();
        test_one_mode(2'b00);
        test_one_mode(2'b01);
        test_one_mode(2'b10);
        test_one_mode(2'b11);
        test_bubbles();
        test_mixed_stream();
        test_midstream_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule